// File: doc/BRIEF.md
# MSI Doorbell Interrupt Controller

This block gathers message-signaled interrupts from devices and turns them into a single interrupt line to the host. A device raises an interrupt by writing its vector number to the one doorbell input. The block records that vector as pending in a bank of 32-bit status words. A matching bank of 32-bit enable words masks or unmasks each vector one by one. The host line is high whenever a vector is both pending and enabled.

Software uses a small 32-bit register port. It scans the status words to find which vectors fired and acknowledges them by writing ones. It reads an enable word, changes the bits it needs, and writes the word back to mask or unmask vectors. Vector numbering and allocation stay with software. The block only decodes the doorbell write, keeps the two banks and combines them into the interrupt line.

Top module: `msi_doorbell_ctrl`

## Requirements
- R1: After reset every status bit and every enable bit reads 0, and `irq` is low.
- R2: A doorbell write with data n below 256 sets pending bit n. That bit lives in the status word at address 0x80 + (n/32)*4, at bit position n%32, and reads as 1 from the cycle after the write.
- R3: A doorbell write with data 256 or above changes no status bit and leaves `irq` unchanged.
- R4: A register write to a status word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: A register write to the enable word at 0xA0 + k*4 replaces that word whole. Reading the word returns the last value written. Enable bit n uses the same word and bit mapping as status bit n, and a 1 unmasks the vector.
- R6: `irq` is high exactly while at least one vector has both its status bit and its enable bit set.
- R7: When a doorbell write and a write-one-to-clear hit the same bit in the same cycle, the bit stays pending.
- R8: A masked vector still latches its status bit. `irq` rises in the cycle after that vector is unmasked.
- R9: Reads from any address outside the two banks return 0. Writes there change no status or enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_valid | input | 1 | Doorbell write strobe |
| db_vector | input | 32 | Doorbell data: vector number |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Combined interrupt to the host |

## Verification
A doorbell or register write takes effect at the next rising edge. The new status and enable values, and the `irq` they produce, are therefore visible one cycle after the strobe. `reg_rdata` follows `reg_addr` with no delay. The bench drives every stimulus for exactly one cycle starting at a falling edge. It then checks `irq` and the read-back words at the next falling edge, one nanosecond after setting the read address. In this way every result is sampled in the first cycle it is due, and the sweeps over all 256 vectors also catch any bit that lands a cycle late.

// File: rtl/msi_doorbell_ctrl.sv
module msi_doorbell_ctrl #(
  parameter int NUM_VEC = 256,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_BASE = 8'h80,
  parameter logic [ADDR_W-1:0] EN_BASE = 8'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              db_valid,
  input  logic [31:0]       db_vector,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  localparam int WORDS = NUM_VEC / 32;
  localparam int VEC_W = $clog2(NUM_VEC);

  logic [NUM_VEC-1:0] status_q, enable_q, db_hit, ack;
  logic db_ok;

  assign db_ok  = db_valid && (db_vector < 32'(NUM_VEC));
  assign db_hit = db_ok ? (NUM_VEC'(1) << db_vector[VEC_W-1:0]) : '0;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam logic [ADDR_W-1:0] SA = STAT_BASE + ADDR_W'(w * 4);
    localparam logic [ADDR_W-1:0] EA = EN_BASE + ADDR_W'(w * 4);

    assign ack[w*32 +: 32] = (reg_we && reg_addr == SA) ? reg_wdata : 32'h0;

    always_ff @(posedge clk) begin
      if (!rst_n)
        enable_q[w*32 +: 32] <= '0;
      else if (reg_we && reg_addr == EA)
        enable_q[w*32 +: 32] <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~ack) | db_hit;
  end

  always_comb begin
    reg_rdata = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (reg_addr == STAT_BASE + ADDR_W'(w * 4)) reg_rdata = status_q[w*32 +: 32];
      if (reg_addr == EN_BASE + ADDR_W'(w * 4))   reg_rdata = enable_q[w*32 +: 32];
    end
  end

  assign irq = |(status_q & enable_q);
endmodule

// File: rtl/msi_doorbell_ctrl_chk.sv
module msi_doorbell_ctrl_chk #(
  parameter int NUM_VEC = 256,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_BASE = 8'h80,
  parameter logic [ADDR_W-1:0] EN_BASE = 8'hA0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               db_valid,
  input logic [31:0]        db_vector,
  input logic               reg_we,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [31:0]        reg_wdata,
  input logic               irq,
  input logic [NUM_VEC-1:0] status_q,
  input logic [NUM_VEC-1:0] enable_q
);
  localparam int VEC_W = $clog2(NUM_VEC);
  logic [VEC_W-1:0] last_vec;
  always_ff @(posedge clk) last_vec <= db_vector[VEC_W-1:0];

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq);

  // R2
  doorbell_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_valid && db_vector < 32'(NUM_VEC) |=> status_q[last_vec]);

  // R3
  range_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_valid && db_vector >= 32'(NUM_VEC) && !reg_we |=> $stable(irq));

  // R4
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == STAT_BASE && reg_wdata[0] && !(db_valid && db_vector == 0)
    |=> !status_q[0]);

  // R5
  enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == EN_BASE |=> enable_q[31:0] == $past(reg_wdata));

  // R7
  doorbell_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_valid && db_vector == 0 && reg_we && reg_addr == STAT_BASE && reg_wdata[0]
    |=> status_q[0]);

  // R8
  unmask_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == EN_BASE && |(reg_wdata & status_q[31:0]) |=> irq);
endmodule

bind msi_doorbell_ctrl msi_doorbell_ctrl_chk #(
  .NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W), .STAT_BASE(STAT_BASE), .EN_BASE(EN_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .db_valid(db_valid), .db_vector(db_vector),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq(irq),
  .status_q(status_q), .enable_q(enable_q)
);

// File: tb/msi_doorbell_ctrl_bench.sv
module msi_doorbell_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic db_valid = 1'b0, reg_we = 1'b0;
  logic [31:0] db_vector = '0, reg_wdata = '0, reg_rdata;
  logic [7:0] reg_addr = '0;
  logic irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  msi_doorbell_ctrl u_msi_doorbell_ctrl (
    .clk(clk), .rst_n(rst_n), .db_valid(db_valid), .db_vector(db_vector),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic cyc(input logic dv, input logic [31:0] dvec,
                     input logic we, input logic [7:0] a, input logic [31:0] wd);
    db_valid = dv; db_vector = dvec; reg_we = we; reg_addr = a; reg_wdata = wd;
    @(negedge clk);
    db_valid = 0; reg_we = 0;
  endtask

  task automatic all_status_zero(input string req);
    logic [31:0] d;
    for (int w = 0; w < 8; w++) begin
      rd(8'h80 + 8'(w * 4), d);
      chk(req, d, 32'h0);
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 irq", {31'b0, irq}, 32'h0);
    all_status_zero("R1 status");
    for (int w = 0; w < 8; w++) begin
      rd(8'hA0 + 8'(w * 4), d);
      chk("R1 enable", d, 32'h0);
    end

    // Sweep of all vectors: R2, R8, R6, R4, R5
    for (int n = 0; n < 256; n++) begin
      logic [7:0] sa, ea;
      logic [31:0] bitv;
      sa = 8'h80 + 8'((n / 32) * 4);
      ea = 8'hA0 + 8'((n / 32) * 4);
      bitv = 32'h1 << (n % 32);
      cyc(1, 32'(n), 0, 0, 0);
      rd(sa, d); chk("R2 pending bit", d, bitv);
      chk("R8 masked no irq", {31'b0, irq}, 32'h0);
      cyc(0, 0, 1, ea, bitv);
      chk("R8 unmask raises irq", {31'b0, irq}, 32'h1);
      rd(ea, d); chk("R5 enable readback", d, bitv);
      cyc(0, 0, 1, sa, bitv);
      rd(sa, d); chk("R4 ack clears", d, 32'h0);
      chk("R6 irq drops", {31'b0, irq}, 32'h0);
      cyc(0, 0, 1, ea, 32'h0);
    end

    // R3 out-of-range vectors, with everything enabled
    for (int w = 0; w < 8; w++) cyc(0, 0, 1, 8'hA0 + 8'(w * 4), 32'hFFFF_FFFF);
    foreach (d[i]) ;
    begin
      logic [31:0] bad [4];
      bad[0] = 256; bad[1] = 257; bad[2] = 511; bad[3] = 32'hFFFF_FFFF;
      for (int i = 0; i < 4; i++) begin
        cyc(1, bad[i], 0, 0, 0);
        chk("R3 irq unchanged", {31'b0, irq}, 32'h0);
        all_status_zero("R3 no status");
      end
    end

    // R4 zero bits untouched, R6 with several pending
    cyc(1, 32'd37, 0, 0, 0);
    cyc(1, 32'd40, 0, 0, 0);
    cyc(0, 0, 1, 8'h84, 32'h0000_0020);
    rd(8'h84, d); chk("R4 zero bits kept", d, 32'h0000_0100);
    chk("R6 irq with remaining", {31'b0, irq}, 32'h1);
    cyc(0, 0, 1, 8'hA4, 32'hFFFF_FEFF);
    chk("R6 masked remaining", {31'b0, irq}, 32'h0);
    rd(8'hA4, d); chk("R5 partial mask readback", d, 32'hFFFF_FEFF);
    cyc(0, 0, 1, 8'h84, 32'hFFFF_FFFF);

    // R7 collision
    for (int n = 0; n < 256; n += 51) begin
      logic [7:0] sa;
      sa = 8'h80 + 8'((n / 32) * 4);
      cyc(1, 32'(n), 1, sa, 32'h1 << (n % 32));
      rd(sa, d); chk("R7 doorbell wins", d, 32'h1 << (n % 32));
      cyc(0, 0, 1, sa, 32'hFFFF_FFFF);
    end

    // R9 unmapped
    cyc(1, 32'd3, 0, 0, 0);
    cyc(0, 0, 1, 8'h00, 32'hFFFF_FFFF);
    cyc(0, 0, 1, 8'hC0, 32'hFFFF_FFFF);
    cyc(0, 0, 1, 8'h7C, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R9 read 0x00", d, 32'h0);
    rd(8'h7C, d); chk("R9 read 0x7C", d, 32'h0);
    rd(8'hC0, d); chk("R9 read 0xC0", d, 32'h0);
    rd(8'h80, d); chk("R9 status kept", d, 32'h0000_0008);
    rd(8'hA0, d); chk("R9 enable kept", d, 32'hFFFF_FFFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule